// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from peripheral lines, from four fixed exception lines, from three debug-event lines and from one software request line. It gives each source a rank and offers the strongest eligible request to the processor core together with a vector address and the rank it was granted. The core answers with an acknowledge strobe when it accepts the request and a return strobe when a handler finishes. The controller keeps an internal stack of granted ranks, so a request interrupts the running handler only if it outranks it. Handlers therefore nest.

Ranks are coded on three bits: 0 none, 1 software (lowest), 2 user level 0, 3 user level 1, 4 user level 2, 5 level 3. Source indices are fixed. Indices 0 to 3 are the exceptions (illegal instruction, stack overflow, misaligned access, software trap). Indices 4 to 6 are the debug events (step counter, breakpoint, trace buffer). Indices 7 to 7+N_PER-1 are the peripherals. The last index, N_PER+7, is the software request.

A small register file is written through one write port. It holds one priority code for each peripheral, the vector base, a fast-slot selector and a fast-slot vector. The controller is a three-state machine. ST_IDLE means nothing is offered. ST_PEND means the request line is high. ST_HOLD is a one-cycle settle state after an acknowledge. The transitions are:
- ST_IDLE to ST_PEND when an eligible request exists.
- ST_PEND to ST_PEND while a request stays eligible and no acknowledge arrives. The offered request is re-chosen every cycle.
- ST_PEND to ST_IDLE when no request is eligible any more.
- ST_PEND to ST_HOLD on an acknowledge.
- ST_HOLD to ST_IDLE always.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, irq_o, lvl_o, act_lvl_o and wake_o are 0, and every peripheral priority code is 3 (disabled), so no peripheral request is offered.
- R2: Writing code c (0, 1 or 2) to address k (k < N_PER) makes peripheral k request at rank c+2, and code 3 disables it. A request that is eligible before a clock edge shows irq_o=1 right after that edge.
- R3: Exception requests (indices 0 to 3) are offered at rank 5 whatever the core mask and the in-service rank are.
- R4: Debug requests (indices 4 to 6) are offered at rank 5 only while the threshold is below 5.
- R5: Apart from the exceptions, a request is offered only if its rank is strictly above the threshold. The threshold is max(core_mask_i, act_lvl_o), so a higher rank preempts the running handler and an equal or lower rank waits.
- R6: Among offered requests of equal rank, the lowest source index wins.
- R7: The fast-slot selector is written at address N_PER+1: bit 15 enables it and the low index bits choose any source. The fast vector is written at address N_PER+2. When the chosen source ties for the top rank, it beats lower indices, and vec_o is the fast vector.
- R8: For a source that is not in the fast slot, vec_o = base + index*2 (16-bit wrap). The base is written at address N_PER and relocates every vector from the next cycle on.
- R9: An acknowledge while irq_o=1 pushes lvl_o onto the rank stack, so act_lvl_o equals it after the edge. irq_o then stays low for two cycles (ST_HOLD, ST_IDLE) before it can rise again.
- R10: A return pops the stack and restores the previous rank. A return in the same cycle as an accepted acknowledge is ignored, and a return with an empty stack leaves act_lvl_o at 0.
- R11: With STK_DEPTH ranks already stacked, an acknowledge is still accepted but the stack and act_lvl_o do not change.
- R12: wake_o goes to 1 one cycle after any enabled source requests, whatever the mask or in-service rank. A disabled peripheral does not raise it.
- R13: The software request (index N_PER+7) has rank 1 and is offered only while the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 4 | Exception request lines, indices 0 to 3 |
| dbg_req_i | input | 3 | Debug-event request lines, indices 4 to 6 |
| per_req_i | input | N_PER | Peripheral request lines |
| sw_req_i | input | 1 | Software request, lowest rank |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | AW | Configuration address |
| cfg_wdata_i | input | VW | Configuration write data |
| core_mask_i | input | 3 | Core's current mask, as a rank |
| ack_i | input | 1 | Core accepts the offered request |
| ret_i | input | 1 | Core has returned from a handler |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | VW | Vector address of the offered request |
| lvl_o | output | 3 | Rank of the offered request |
| act_lvl_o | output | 3 | Rank on top of the stack (0 when empty) |
| wake_o | output | 1 | Wake notification to the clock/system module |

## Verification
The assertions assume that the core raises acknowledge only in cycles it chooses and that the request inputs are sampled cleanly at each edge. They make no assumption about how long a request is held. The bench drives inputs only at falling edges. It drops each request in the cycle after the request is acknowledged, so an unmaskable line is never left asserted by accident. It pops the stack back to empty between scenarios, so every expected rank and vector follows from the configuration written in that scenario alone.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int unsigned N_EXC    = 4;
    localparam int unsigned N_DBG    = 3;
    localparam int unsigned IDX_DBG0 = 4;
    localparam int unsigned IDX_PER0 = 7;

    localparam logic [2:0] RK_NONE = 3'd0;
    localparam logic [2:0] RK_LP   = 3'd1;
    localparam logic [2:0] RK_L3   = 3'd5;

    localparam logic [1:0] PR_OFF  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_HOLD = 2'd2
    } nic_state_e;
endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
    import nic_pkg::*;
#(
    parameter int unsigned N_PER = 8,
    parameter int unsigned AW    = 4,
    parameter int unsigned SW    = 4,
    parameter int unsigned VW    = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   we_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [VW-1:0]          wdata_i,
    output logic [N_PER-1:0][1:0]  prio_o,
    output logic [VW-1:0]          base_o,
    output logic                   fast_en_o,
    output logic [SW-1:0]          fast_sel_o,
    output logic [VW-1:0]          fast_vec_o
);
    localparam int unsigned A_BASE = N_PER;
    localparam int unsigned A_FSEL = N_PER + 1;
    localparam int unsigned A_FVEC = N_PER + 2;

    logic [VW-1:0] base_q;
    logic [VW-1:0] fsel_q;
    logic [VW-1:0] fvec_q;
    logic          unused_fsel;

    // one priority code per peripheral
    for (genvar k = 0; k < N_PER; k++) begin : g_prio
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                prio_o[k] <= PR_OFF;
            end else if (we_i && addr_i == AW'(k)) begin
                prio_o[k] <= wdata_i[1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            base_q <= '0;
            fsel_q <= '0;
            fvec_q <= '0;
        end else if (we_i) begin
            if (addr_i == AW'(A_BASE)) base_q <= wdata_i;
            if (addr_i == AW'(A_FSEL)) fsel_q <= wdata_i;
            if (addr_i == AW'(A_FVEC)) fvec_q <= wdata_i;
        end
    end

    assign base_o      = base_q;
    assign fast_en_o   = fsel_q[VW-1];
    assign fast_sel_o  = fsel_q[SW-1:0];
    assign fast_vec_o  = fvec_q;
    assign unused_fsel = ^fsel_q[VW-2:SW];
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int unsigned N_PER = 8,
    parameter int unsigned SW    = 4,
    parameter int unsigned VW    = 16,
    parameter int unsigned VSH   = 1
) (
    input  logic [N_EXC-1:0]       exc_req_i,
    input  logic [N_DBG-1:0]       dbg_req_i,
    input  logic [N_PER-1:0]       per_req_i,
    input  logic                   sw_req_i,
    input  logic [N_PER-1:0][1:0]  prio_i,
    input  logic [2:0]             thr_i,
    input  logic [VW-1:0]          base_i,
    input  logic                   fast_en_i,
    input  logic [SW-1:0]          fast_sel_i,
    input  logic [VW-1:0]          fast_vec_i,
    output logic                   win_v_o,
    output logic [2:0]             win_rank_o,
    output logic [VW-1:0]          win_vec_o,
    output logic                   wake_o
);
    localparam int unsigned NSRC   = N_PER + IDX_PER0 + 1;
    localparam int unsigned IDX_SW = NSRC - 1;

    logic [2:0]    raw [NSRC];
    logic [2:0]    elg [NSRC];
    logic [2:0]    best_r;
    logic [SW-1:0] best_i;
    logic          fast_hit;

    // raw rank of every requesting source
    always_comb begin
        for (int i = 0; i < int'(N_EXC); i++) begin
            raw[i] = exc_req_i[i] ? RK_L3 : RK_NONE;
        end
        for (int i = 0; i < int'(N_DBG); i++) begin
            raw[IDX_DBG0 + i] = dbg_req_i[i] ? RK_L3 : RK_NONE;
        end
        for (int k = 0; k < int'(N_PER); k++) begin
            raw[IDX_PER0 + k] = (per_req_i[k] && prio_i[k] != PR_OFF)
                              ? (3'(prio_i[k]) + 3'd2) : RK_NONE;
        end
        raw[IDX_SW] = sw_req_i ? RK_LP : RK_NONE;
    end

    // threshold filter; exceptions bypass it
    always_comb begin
        for (int i = 0; i < int'(NSRC); i++) begin
            if (i < int'(N_EXC)) begin
                elg[i] = raw[i];
            end else begin
                elg[i] = (raw[i] > thr_i) ? raw[i] : RK_NONE;
            end
        end
    end

    always_comb begin
        wake_o = 1'b0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (raw[i] != RK_NONE) wake_o = 1'b1;
        end
    end

    // highest rank, lowest index on ties
    always_comb begin
        best_r = RK_NONE;
        best_i = '0;
        for (int i = int'(NSRC) - 1; i >= 0; i--) begin
            if (elg[i] != RK_NONE && elg[i] >= best_r) begin
                best_r = elg[i];
                best_i = SW'(i);
            end
        end
        fast_hit = 1'b0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (fast_en_i && fast_sel_i == SW'(i) &&
                elg[i] != RK_NONE && elg[i] == best_r) begin
                fast_hit = 1'b1;
            end
        end
    end

    assign win_v_o    = (best_r != RK_NONE);
    assign win_rank_o = best_r;
    assign win_vec_o  = fast_hit ? fast_vec_i
                                 : base_i + (VW'(best_i) << VSH);
endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o,
    output logic         full_o
);
    localparam int unsigned PW = $clog2(DEPTH + 1);

    logic [PW-1:0] ptr_q;
    logic [W-1:0]  ent_q [DEPTH];
    logic          empty;
    logic          do_push;
    logic          do_pop;

    assign full_o  = (ptr_q == PW'(DEPTH));
    assign empty   = (ptr_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !push_i && !empty;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else if (do_push) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (do_pop) begin
            ptr_q <= ptr_q - 1'b1;
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                ent_q[k] <= '0;
            end else if (do_push && ptr_q == PW'(k)) begin
                ent_q[k] <= din_i;
            end
        end
    end

    always_comb begin
        top_o = '0;
        for (int k = 0; k < int'(DEPTH); k++) begin
            if (ptr_q == PW'(k + 1)) top_o = ent_q[k];
        end
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int unsigned N_PER     = 8,
    parameter int unsigned STK_DEPTH = 4,
    parameter int unsigned VW        = 16,
    parameter int unsigned VSH       = 1,
    localparam int unsigned NSRC     = N_PER + IDX_PER0 + 1,
    localparam int unsigned SW       = $clog2(NSRC),
    localparam int unsigned AW       = $clog2(N_PER + 3)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_EXC-1:0]   exc_req_i,
    input  logic [N_DBG-1:0]   dbg_req_i,
    input  logic [N_PER-1:0]   per_req_i,
    input  logic               sw_req_i,
    input  logic               cfg_we_i,
    input  logic [AW-1:0]      cfg_addr_i,
    input  logic [VW-1:0]      cfg_wdata_i,
    input  logic [2:0]         core_mask_i,
    input  logic               ack_i,
    input  logic               ret_i,
    output logic               irq_o,
    output logic [VW-1:0]      vec_o,
    output logic [2:0]         lvl_o,
    output logic [2:0]         act_lvl_o,
    output logic               wake_o
);
    logic [N_PER-1:0][1:0] prio;
    logic [VW-1:0]         base;
    logic                  fast_en;
    logic [SW-1:0]         fast_sel;
    logic [VW-1:0]         fast_vec;

    logic [2:0]            thr;
    logic [2:0]            stk_top;
    logic                  stk_full;
    logic                  win_v;
    logic [2:0]            win_rank;
    logic [VW-1:0]         win_vec;
    logic                  wake_c;

    nic_state_e            state_q, state_d;
    logic [2:0]            lvl_q;
    logic [VW-1:0]         vec_q;
    logic                  wake_q;
    logic                  push;

    nic_cfg_regs #(.N_PER(N_PER), .AW(AW), .SW(SW), .VW(VW)) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (cfg_we_i),
        .addr_i     (cfg_addr_i),
        .wdata_i    (cfg_wdata_i),
        .prio_o     (prio),
        .base_o     (base),
        .fast_en_o  (fast_en),
        .fast_sel_o (fast_sel),
        .fast_vec_o (fast_vec)
    );

    assign thr = (core_mask_i > stk_top) ? core_mask_i : stk_top;

    nic_arbiter #(.N_PER(N_PER), .SW(SW), .VW(VW), .VSH(VSH)) u_arb (
        .exc_req_i  (exc_req_i),
        .dbg_req_i  (dbg_req_i),
        .per_req_i  (per_req_i),
        .sw_req_i   (sw_req_i),
        .prio_i     (prio),
        .thr_i      (thr),
        .base_i     (base),
        .fast_en_i  (fast_en),
        .fast_sel_i (fast_sel),
        .fast_vec_i (fast_vec),
        .win_v_o    (win_v),
        .win_rank_o (win_rank),
        .win_vec_o  (win_vec),
        .wake_o     (wake_c)
    );

    assign push = (state_q == ST_PEND) && ack_i;

    nic_lvl_stack #(.DEPTH(STK_DEPTH), .W(3)) u_stk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (push),
        .pop_i  (ret_i),
        .din_i  (lvl_q),
        .top_o  (stk_top),
        .full_o (stk_full)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = win_v ? ST_PEND : ST_IDLE;
            ST_PEND: begin
                if (ack_i)      state_d = ST_HOLD;
                else if (win_v) state_d = ST_PEND;
                else            state_d = ST_IDLE;
            end
            ST_HOLD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_q  <= '0;
            vec_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= wake_c;
            if (state_d == ST_PEND) begin
                lvl_q <= win_rank;
                vec_q <= win_vec;
            end else begin
                lvl_q <= '0;
            end
        end
    end

    assign irq_o     = (state_q == ST_PEND);
    assign lvl_o     = lvl_q;
    assign vec_o     = vec_q;
    assign act_lvl_o = stk_top;
    assign wake_o    = wake_q;
endmodule

// File: rtl/nic_chk.sv
module nic_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       irq_o,
    input logic       ack_i,
    input logic [2:0] lvl_o,
    input logic [2:0] act_lvl_o,
    input logic [2:0] core_mask_i,
    input logic [3:0] exc_req_i,
    input logic       wake_o,
    input logic       stk_full
);
    AST_NEST_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && lvl_o != 3'd5) |-> (lvl_o > $past(act_lvl_o) && lvl_o > $past(core_mask_i))); // R5
    AST_EXC_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|exc_req_i) |=> (!irq_o || lvl_o == 3'd5)); // R3
    AST_ACK_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o && !stk_full) |=> (act_lvl_o == $past(lvl_o))); // R9
    AST_ACK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o) |=> !irq_o); // R9
    AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o && stk_full) |=> $stable(act_lvl_o)); // R11
    AST_WAKE_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|exc_req_i) |=> wake_o); // R12
endmodule

bind nest_irq_ctrl nic_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_o       (irq_o),
    .ack_i       (ack_i),
    .lvl_o       (lvl_o),
    .act_lvl_o   (act_lvl_o),
    .core_mask_i (core_mask_i),
    .exc_req_i   (exc_req_i),
    .wake_o      (wake_o),
    .stk_full    (stk_full)
);

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
    localparam int NP = 8;
    localparam int A_BASE = NP, A_FSEL = NP + 1, A_FVEC = NP + 2;
    localparam int IDX_SW = NP + 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  exc_req = '0;
    logic [2:0]  dbg_req = '0;
    logic [NP-1:0] per_req = '0;
    logic        sw_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  core_mask = '0;
    logic        ack = 1'b0;
    logic        ret = 1'b0;
    logic        irq;
    logic [15:0] vec;
    logic [2:0]  lvl;
    logic [2:0]  act;
    logic        wake;

    int errors = 0;
    int checks = 0;
    int base = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nest_irq_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .dbg_req_i(dbg_req),
        .per_req_i(per_req), .sw_req_i(sw_req), .cfg_we_i(cfg_we),
        .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .core_mask_i(core_mask),
        .ack_i(ack), .ret_i(ret), .irq_o(irq), .vec_o(vec), .lvl_o(lvl),
        .act_lvl_o(act), .wake_o(wake)
    );

    task automatic chk(input string tag, input int actual, input int expv);
        checks++;
        if (actual != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expv);
        end
    endtask

    function automatic int ev(input int idx);
        return (base + idx * 2) & 16'hFFFF;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic drop();
        exc_req = '0; dbg_req = '0; per_req = '0; sw_req = 1'b0;
    endtask

    task automatic settle();
        drop(); core_mask = '0; ack = 1'b0;
        ret = 1'b1;
        repeat (6) step();
        ret = 1'b0;
        step();
    endtask

    task automatic grant();
        ack = 1'b1;
        step();
        ack = 1'b0;
        drop();
    endtask

    task automatic pop();
        ret = 1'b1;
        step();
        ret = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 act", act, 0);
        chk("R1 wake", wake, 0);
        per_req[0] = 1'b1;
        step(); step();
        chk("R1 disabled irq", irq, 0);
        chk("R1 disabled wake", wake, 0);
        drop(); step();

        // R2 / R8 sweep of peripherals and codes
        base = 16'h0100;
        wr(A_BASE, base);
        for (int k = 0; k < NP; k++) begin
            for (int p = 0; p < 3; p++) begin
                wr(k, p);
                per_req[k] = 1'b1;
                step();
                chk("R2 irq", irq, 1);
                chk("R2 lvl", lvl, p + 2);
                chk("R8 vec", vec, ev(7 + k));
                grant();
                chk("R9 push", act, p + 2);
                chk("R9 irq low", irq, 0);
                pop();
                chk("R10 pop", act, 0);
                wr(k, 3);
            end
        end

        // R6 ties at equal rank
        for (int k = 0; k < NP; k++) wr(k, 1);
        for (int i = 0; i < NP; i++) begin
            for (int j = i + 1; j < NP; j++) begin
                per_req = '0;
                per_req[i] = 1'b1; per_req[j] = 1'b1;
                step();
                chk("R6 tie vec", vec, ev(7 + i));
                drop(); step();
            end
        end

        // R5 mask sweep with codes 0,1,2 on peripherals 0..2
        wr(0, 0); wr(1, 1); wr(2, 2);
        for (int m = 0; m < 6; m++) begin
            core_mask = 3'(m);
            per_req = 8'b0000_0111;
            step();
            chk("R5 mask irq", irq, (m < 4) ? 1 : 0);
            if (m < 4) chk("R5 mask lvl", lvl, 4);
            drop(); step();
        end
        core_mask = '0;

        // R5 / R9 nesting and gap
        per_req[1] = 1'b1;
        step();
        chk("R5 serve L1", lvl, 3);
        grant();
        per_req[0] = 1'b1;
        step();
        chk("R9 gap", irq, 0);
        step();
        chk("R5 lower waits", irq, 0);
        per_req[2] = 1'b1;
        step();
        chk("R5 preempt irq", irq, 1);
        chk("R5 preempt lvl", lvl, 4);
        settle();

        // R3 exceptions beat mask and in-service rank
        core_mask = 3'd5;
        for (int e = 0; e < 4; e++) begin
            exc_req[e] = 1'b1;
            step();
            chk("R3 exc irq", irq, 1);
            chk("R3 exc lvl", lvl, 5);
            chk("R3 exc vec", vec, ev(e));
            grant();
            step();
        end
        chk("R3 nested depth top", act, 5);
        settle();

        // R4 debug events and R12 wake
        for (int d = 0; d < 3; d++) begin
            core_mask = 3'd0;
            dbg_req[d] = 1'b1;
            step();
            chk("R4 dbg lvl", lvl, 5);
            chk("R4 dbg vec", vec, ev(4 + d));
            drop(); step();
            core_mask = 3'd5;
            dbg_req[d] = 1'b1;
            step();
            chk("R4 dbg masked", irq, 0);
            chk("R12 wake masked", wake, 1);
            drop(); step();
        end
        core_mask = '0;

        // R13 software request
        sw_req = 1'b1;
        step();
        chk("R13 sw lvl", lvl, 1);
        chk("R13 sw vec", vec, ev(IDX_SW));
        core_mask = 3'd1;
        step();
        chk("R13 sw masked", irq, 0);
        settle();

        // R7 fast slot on peripheral 5 (index 12)
        wr(3, 1); wr(5, 1);
        wr(A_FVEC, 16'h2000);
        wr(A_FSEL, 16'h8000 | 12);
        per_req[3] = 1'b1; per_req[5] = 1'b1;
        step();
        chk("R7 fast vec", vec, 16'h2000);
        chk("R7 fast lvl", lvl, 3);
        wr(5, 0);
        step();
        chk("R7 lower fast loses", vec, ev(10));
        wr(5, 1); wr(A_FSEL, 12);
        step();
        chk("R7 disabled", vec, ev(10));
        drop(); step();

        // R8 relocation
        base = 16'h4000;
        wr(A_BASE, base);
        wr(0, 2);
        per_req[0] = 1'b1;
        step();
        chk("R8 relocated vec", vec, ev(7));
        settle();

        // R10 / R11 stack fill and unwind
        wr(0, 0); wr(1, 1); wr(2, 2);
        per_req[0] = 1'b1; step(); grant(); step();
        per_req[1] = 1'b1; step(); grant(); step();
        per_req[2] = 1'b1; step(); grant(); step();
        dbg_req[0] = 1'b1; step(); grant(); step();
        chk("R11 filled", act, 5);
        exc_req[0] = 1'b1;
        step();
        chk("R11 exc offered", irq, 1);
        grant();
        chk("R11 no push", act, 5);
        chk("R11 ack taken", irq, 0);
        step();
        pop(); chk("R10 pop 4", act, 4);
        pop(); chk("R10 pop 3", act, 3);
        pop(); chk("R10 pop 2", act, 2);
        pop(); chk("R10 pop 0", act, 0);
        pop(); chk("R10 empty pop", act, 0);
        per_req[0] = 1'b1;
        step();
        ack = 1'b1; ret = 1'b1;
        step();
        ack = 1'b0; ret = 1'b0; drop();
        chk("R10 ret with ack ignored", act, 2);
        pop();
        chk("R10 final pop", act, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule